// File: doc/BRIEF.md
# Program Flow and Return Stack Unit

This unit owns the program counter of a small 8-bit processor and a private return-address stack. Each clock it receives one decoded flow command (hold, advance, jump, call, return or restart) together with the length of the current instruction, a 3-bit condition selector, four status flags and two operand bytes that form a branch target. It tests the condition, picks the next program counter and, for calls and restarts, saves the address of the following instruction on the stack. For returns it restores a saved address.

The condition selector works in two parts. Its two low bits choose one flag. Its top bit chooses whether that flag must be set or clear. The stack is a small register file with a circular pointer. Overflow and underflow wrap around without any signal, as in the small processors this unit models. Instruction fetch, the ALU and data memory sit outside the unit.

Top module: `prog_flow_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter becomes 0, `taken` becomes 0, the stack pointer is emptied and every stack slot is cleared.
- R2: `cond_sel[1:0]` picks a flag: 0 carry, 1 zero, 2 sign, 3 parity. The parity flag is 1 for even parity. The condition holds when the chosen flag equals `cond_sel[2]`. For example, selector 3 means parity odd and selector 7 means parity even.
- R3: A jump (`cmd`=2) with `cond_use`=1 loads the target when the condition holds. Otherwise it sets PC to PC+`insn_len`. `taken` is 1 in the cycle after a transfer that took effect and 0 after any other command.
- R4: When `cond_use`=0, the jump, call and return commands ignore the condition and the flags.
- R5: A call (`cmd`=3) that goes ahead pushes PC+`insn_len` and loads the target. A conditional call whose condition fails only sets PC to PC+`insn_len` and leaves the stack unchanged.
- R6: A return (`cmd`=4) that goes ahead loads PC from the most recent stack entry and pops it. A conditional return whose condition fails sets PC to PC+`insn_len` and leaves the stack unchanged.
- R7: A restart (`cmd`=5) is always unconditional. It pushes PC+`insn_len` and loads PC with `rst_vec`×8.
- R8: The target is `{addr_hi[5:0], addr_lo}`. Bits 7:6 of `addr_hi` have no effect.
- R9: The stack holds 7 entries. An eighth push without an intervening pop overwrites the oldest entry, and later pops run circularly through the slots.
- R10: A pop from an empty stack wraps the pointer to the top slot and returns that slot's contents.
- R11: The idle command (`cmd`=0, and the unused codes 6 and 7) holds the PC. Advance (`cmd`=1) adds `insn_len`, and the PC wraps modulo 2^14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Flow command: 0 idle, 1 advance, 2 jump, 3 call, 4 return, 5 restart |
| cond_use | input | 1 | 1 makes jump/call/return conditional |
| cond_sel | input | 3 | Condition selector (flag index and polarity) |
| flag_carry | input | 1 | Carry flag |
| flag_zero | input | 1 | Zero flag |
| flag_sign | input | 1 | Sign flag |
| flag_parity | input | 1 | Parity flag, 1 = even |
| addr_lo | input | 8 | Low target byte |
| addr_hi | input | 8 | High target byte, low 6 bits used |
| rst_vec | input | 3 | Restart vector number |
| insn_len | input | 2 | Length in bytes of the current instruction |
| pc | output | 14 | Program counter |
| taken | output | 1 | Last command transferred control |

## Verification
The bench builds the unit with its default parameters: a 14-bit PC, 8-bit operand bytes and a 7-entry stack. A depth that is not a power of two makes the pointer wrap at 6→0 instead of at its natural rollover, and eight calls followed by eight returns reach it. The 14-bit PC leaves two high-byte bits unused, and the bench drives them to non-zero values on every target. All eight condition selectors are tried against three flag patterns.

// File: rtl/pfu_pkg.sv
`timescale 1ns/1ps
package pfu_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE = 3'd0,
        CMD_SEQ  = 3'd1,
        CMD_JUMP = 3'd2,
        CMD_CALL = 3'd3,
        CMD_RET  = 3'd4,
        CMD_RST  = 3'd5
    } flow_cmd_e;

    localparam int FLAG_N = 4;
    localparam int COND_W = 3;
    localparam int VEC_W  = 3;
    localparam int LEN_W  = 2;
endpackage

// File: rtl/pfu_cond_eval.sv
`timescale 1ns/1ps
module pfu_cond_eval
    import pfu_pkg::*;
(
    input  logic [COND_W-1:0] cond_sel,
    input  logic [FLAG_N-1:0] flags,
    output logic              cond_ok
);
    logic picked;

    always_comb begin
        picked  = flags[cond_sel[1:0]];
        cond_ok = (picked == cond_sel[2]);
    end
endmodule

// File: rtl/pfu_ret_stack.sv
`timescale 1ns/1ps
module pfu_ret_stack #(
    parameter int DEPTH = 7,
    parameter int W     = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] TOP = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PW-1:0]           sp;
    } stk_t;

    stk_t st_d, st_q;
    logic [PW-1:0] rd_idx;
    logic [PW-1:0] sp_up;

    always_comb begin
        rd_idx = (st_q.sp == '0) ? TOP : st_q.sp - PW'(1);
        sp_up  = (st_q.sp == TOP) ? '0 : st_q.sp + PW'(1);
        rdata  = st_q.slot[rd_idx];
        st_d   = st_q;
        if (push) begin
            st_d.slot[st_q.sp] = wdata;
            st_d.sp            = sp_up;
        end else if (pop) begin
            st_d.sp = rd_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assert_wrap_up_R9: assert property (@(posedge clk) disable iff (rst)
        (push && st_q.sp == TOP) |=> (st_q.sp == '0));

    assert_wrap_down_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && st_q.sp == '0) |=> (st_q.sp == TOP));

    assert_push_pop_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: rtl/pfu_next_pc.sv
`timescale 1ns/1ps
module pfu_next_pc
    import pfu_pkg::*;
#(
    parameter int PC_W   = 14,
    parameter int BYTE_W = 8
) (
    input  flow_cmd_e          cmd,
    input  logic               cond_use,
    input  logic               cond_ok,
    input  logic [PC_W-1:0]    pc_q,
    input  logic [LEN_W-1:0]   insn_len,
    input  logic [BYTE_W-1:0]  addr_lo,
    input  logic [BYTE_W-1:0]  addr_hi,
    input  logic [VEC_W-1:0]   rst_vec,
    input  logic [PC_W-1:0]    pop_data,
    output logic [PC_W-1:0]    pc_d,
    output logic [PC_W-1:0]    push_data,
    output logic               push,
    output logic               pop,
    output logic               taken_d
);
    localparam int HI_W = PC_W - BYTE_W;

    logic [PC_W-1:0] pc_seq;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] vec_addr;
    logic            go;

    always_comb begin
        pc_seq    = pc_q + PC_W'(insn_len);
        target    = {addr_hi[HI_W-1:0], addr_lo};
        vec_addr  = PC_W'({rst_vec, 3'b000});
        go        = !cond_use || cond_ok;
        push_data = pc_seq;
        pc_d      = pc_q;
        push      = 1'b0;
        pop       = 1'b0;
        taken_d   = 1'b0;
        case (cmd)
            CMD_SEQ: pc_d = pc_seq;
            CMD_JUMP: begin
                pc_d    = go ? target : pc_seq;
                taken_d = go;
            end
            CMD_CALL: begin
                pc_d    = go ? target : pc_seq;
                push    = go;
                taken_d = go;
            end
            CMD_RET: begin
                pc_d    = go ? pop_data : pc_seq;
                pop     = go;
                taken_d = go;
            end
            CMD_RST: begin
                pc_d    = vec_addr;
                push    = 1'b1;
                taken_d = 1'b1;
            end
            default: pc_d = pc_q;
        endcase
    end
endmodule

// File: rtl/prog_flow_unit.sv
`timescale 1ns/1ps
module prog_flow_unit
    import pfu_pkg::*;
#(
    parameter int PC_W        = 14,
    parameter int BYTE_W      = 8,
    parameter int STACK_DEPTH = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic              cond_use,
    input  logic [2:0]        cond_sel,
    input  logic              flag_carry,
    input  logic              flag_zero,
    input  logic              flag_sign,
    input  logic              flag_parity,
    input  logic [BYTE_W-1:0] addr_lo,
    input  logic [BYTE_W-1:0] addr_hi,
    input  logic [2:0]        rst_vec,
    input  logic [1:0]        insn_len,
    output logic [PC_W-1:0]   pc,
    output logic              taken
);
    localparam int HI_W = PC_W - BYTE_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            taken;
    } flow_t;

    flow_t st_d, st_q;

    flow_cmd_e       cmd_e;
    logic [FLAG_N-1:0] flags;
    logic            cond_ok;
    logic [PC_W-1:0] pc_nx, push_data, pop_data;
    logic            push, pop, taken_nx;

    assign cmd_e = flow_cmd_e'(cmd);
    assign flags = {flag_parity, flag_sign, flag_zero, flag_carry};

    pfu_cond_eval u_cond (
        .cond_sel (cond_sel),
        .flags    (flags),
        .cond_ok  (cond_ok)
    );

    pfu_next_pc #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_next (
        .cmd       (cmd_e),
        .cond_use  (cond_use),
        .cond_ok   (cond_ok),
        .pc_q      (st_q.pc),
        .insn_len  (insn_len),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi),
        .rst_vec   (rst_vec),
        .pop_data  (pop_data),
        .pc_d      (pc_nx),
        .push_data (push_data),
        .push      (push),
        .pop       (pop),
        .taken_d   (taken_nx)
    );

    pfu_ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .wdata (push_data),
        .rdata (pop_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pc    = pc_nx;
        st_d.taken = taken_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pc    = st_q.pc;
    assign taken = st_q.taken;

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd0) |=> ($stable(pc) && !taken));

    assert_skip_len_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2 && cond_use && !cond_ok) |=>
        (pc == $past(pc) + PC_W'($past(insn_len))));

    assert_rst_vector_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd5) |=> (pc == PC_W'({$past(rst_vec), 3'b000}) && taken));

    assert_target_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2 && !cond_use) |=>
        (pc == {$past(addr_hi[HI_W-1:0]), $past(addr_lo)}));
endmodule

// File: tb/prog_flow_unit_bench.sv
`timescale 1ns/1ps
module prog_flow_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = 3'd0;
    logic        cond_use = 1'b0;
    logic [2:0]  cond_sel = 3'd0;
    logic        flag_carry = 1'b0, flag_zero = 1'b0, flag_sign = 1'b0, flag_parity = 1'b0;
    logic [7:0]  addr_lo = 8'd0, addr_hi = 8'd0;
    logic [2:0]  rst_vec = 3'd0;
    logic [1:0]  insn_len = 2'd0;
    logic [13:0] pc;
    logic        taken;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    prog_flow_unit u_prog_flow_unit (
        .clk(clk), .rst(rst), .cmd(cmd), .cond_use(cond_use), .cond_sel(cond_sel),
        .flag_carry(flag_carry), .flag_zero(flag_zero), .flag_sign(flag_sign),
        .flag_parity(flag_parity), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .rst_vec(rst_vec), .insn_len(insn_len), .pc(pc), .taken(taken)
    );

    task automatic check(input string req, input logic [13:0] got, input logic [13:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive one command at a falling edge, let one rising edge act on it,
    // then return at the next falling edge with the result visible
    task automatic op(input logic [2:0] c, input logic cu, input logic [2:0] cs,
                      input logic [3:0] fl, input logic [13:0] tgt,
                      input logic [2:0] v, input logic [1:0] ln);
        cmd = c; cond_use = cu; cond_sel = cs;
        {flag_parity, flag_sign, flag_zero, flag_carry} = fl;
        addr_lo = tgt[7:0];
        addr_hi = {2'b10, tgt[13:8]};
        rst_vec = v; insn_len = ln;
        @(posedge clk);
        @(negedge clk);
        cmd = 3'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pc", pc, 14'd0);
        check("R1 taken", 14'(taken), 14'd0);
    endtask

    task automatic t_seq();
        op(3'd1, 0, 0, 4'h0, 14'h0, 0, 2'd1); check("R11 adv1", pc, 14'd1);
        op(3'd1, 0, 0, 4'h0, 14'h0, 0, 2'd3); check("R11 adv3", pc, 14'd4);
        op(3'd1, 0, 0, 4'h0, 14'h0, 0, 2'd2); check("R11 adv2", pc, 14'd6);
        op(3'd0, 0, 0, 4'h0, 14'h0, 0, 2'd3); check("R11 idle", pc, 14'd6);
        op(3'd7, 0, 0, 4'h0, 14'h0, 0, 2'd3); check("R11 code7", pc, 14'd6);
        op(3'd2, 0, 0, 4'h0, 14'h3FFF, 0, 2'd1);
        op(3'd1, 0, 0, 4'h0, 14'h0, 0, 2'd2); check("R11 wrap", pc, 14'd1);
    endtask

    // masks list which selectors hold for each flag pattern {parity,sign,zero,carry}
    task automatic t_cond();
        logic [3:0] pats  [3] = '{4'b0000, 4'b1111, 4'b0101};
        logic [7:0] masks [3] = '{8'b00001111, 8'b11110000, 8'b01011010};
        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 8; s++) begin
                logic [13:0] start, tgt;
                start = pc;
                tgt   = 14'h1000 + 14'(p * 64 + s * 4);
                op(3'd2, 1, 3'(s), pats[p], tgt, 0, 2'd1);
                if (masks[p][s]) check("R2 R3 taken jump", pc, tgt);
                else             check("R2 R3 skipped jump", pc, start + 14'd1);
                check("R3 taken flag", 14'(taken), 14'(masks[p][s]));
            end
        end
    endtask

    task automatic t_uncond();
        op(3'd2, 0, 3'd4, 4'b0000, 14'h3ABC, 0, 2'd3);
        check("R4 R8 uncond jump", pc, 14'h3ABC);
        op(3'd3, 0, 3'd5, 4'b0000, 14'h0155, 0, 2'd3);
        check("R4 uncond call", pc, 14'h0155);
        op(3'd4, 0, 3'd6, 4'b0000, 14'h0, 0, 2'd1);
        check("R4 uncond ret", pc, 14'h3ABF);
    endtask

    task automatic t_call_ret();
        op(3'd2, 0, 0, 4'h0, 14'h0100, 0, 2'd3);
        op(3'd3, 1, 3'd4, 4'b0001, 14'h0200, 0, 2'd3);
        check("R5 cond call taken", pc, 14'h0200);
        op(3'd3, 1, 3'd4, 4'b0000, 14'h0300, 0, 2'd3);
        check("R5 cond call skipped", pc, 14'h0203);
        op(3'd4, 1, 3'd5, 4'b0000, 14'h0, 0, 2'd1);
        check("R6 cond ret skipped", pc, 14'h0204);
        op(3'd4, 1, 3'd1, 4'b0000, 14'h0, 0, 2'd1);
        check("R5 R6 ret value", pc, 14'h0103);
    endtask

    task automatic t_restart();
        op(3'd2, 0, 0, 4'h0, 14'h0777, 0, 2'd1);
        op(3'd5, 1, 3'd4, 4'b0000, 14'h2222, 3'd5, 2'd1);
        check("R7 vector", pc, 14'h0028);
        op(3'd5, 0, 0, 4'h0, 14'h0, 3'd7, 2'd1);
        check("R7 vector7", pc, 14'h0038);
        op(3'd4, 0, 0, 4'h0, 14'h0, 0, 2'd1);
        check("R7 ret1", pc, 14'h0029);
        op(3'd4, 0, 0, 4'h0, 14'h0, 0, 2'd1);
        check("R7 ret2", pc, 14'h0778);
    endtask

    task automatic t_overflow();
        logic [13:0] saved [8];
        do_reset();
        for (int k = 0; k < 8; k++) begin
            saved[k] = pc + 14'd3;
            op(3'd3, 0, 0, 4'h0, 14'((k + 1) * 256), 0, 2'd3);
        end
        for (int k = 7; k >= 1; k--) begin
            op(3'd4, 0, 0, 4'h0, 14'h0, 0, 2'd1);
            check("R9 overflow pop", pc, saved[k]);
        end
        op(3'd4, 0, 0, 4'h0, 14'h0, 0, 2'd1);
        check("R9 overwritten slot", pc, saved[7]);
    endtask

    task automatic t_underflow();
        logic [13:0] saved [7];
        do_reset();
        for (int k = 0; k < 7; k++) begin
            saved[k] = pc + 14'd2;
            op(3'd3, 0, 0, 4'h0, 14'((k + 1) * 512), 0, 2'd2);
        end
        for (int k = 6; k >= 0; k--) begin
            op(3'd4, 0, 0, 4'h0, 14'h0, 0, 2'd1);
            check("R10 drain", pc, saved[k]);
        end
        op(3'd4, 0, 0, 4'h0, 14'h0, 0, 2'd1);
        check("R10 underflow wrap", pc, saved[6]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_seq();
        t_cond();
        t_uncond();
        t_call_ret();
        t_restart();
        t_overflow();
        t_underflow();
        do_reset();
        check("R1 pc after reset", pc, 14'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule